// File: doc/BRIEF.md
# Load-Use Stall Detector

This block sits between the decode and execute stages of a five-stage in-order pipeline. It checks whether the instruction now in execute is a load whose destination register is a source of the instruction now in decode. When it is, it raises a stall in the same cycle. The stall freezes the decode latch, turns the execute slot into a bubble and lets the load move on towards memory. Operand forwarding, branch handling and the register file are handled elsewhere.

The comparison follows the consumer's instruction format. A three-register consumer is checked against both of its source fields. A load, store or immediate-ALU consumer is checked against its first (base) source only. Each instruction carries a 3-bit class code: 0 for three-register, 1 for load (byte, half, word or address), 2 for store, 3 for immediate ALU, and 4 to 7 for other. The producer's destination is its `rt` field.

A thin wrapper holds the decode latch, the execute latch and the execute-to-memory latch, so that stall and bubble behaviour can be seen over several cycles. A small controller with three named states tracks the decode latch:
- `DS_EMPTY`: no instruction.
- `DS_FRESH`: newly captured.
- `DS_HELD`: kept back by a stall.

Its transitions:
- EMPTY to FRESH on a valid input.
- FRESH or HELD to HELD on a stall.
- FRESH or HELD to FRESH on a valid input with no stall.
- FRESH or HELD to EMPTY on an invalid input with no stall.
- EMPTY to EMPTY otherwise.

Top module: `lu_stall_pipe`

## Requirements
- R1: A stall occurs only when the execute latch is valid and holds class 1 (load). A non-load producer with a matching `rt` never stalls.
- R2: A stall occurs only when the decode latch is valid. An invalid slot with matching register fields never stalls.
- R3: When the decode instruction is class 0 (three-register), a stall occurs when the load's `rt` equals the consumer's `rs` or the consumer's `rt`.
- R4: When the decode instruction is class 1, 2 or 3, a stall occurs when the load's `rt` equals the consumer's `rs`. A match on the consumer's `rt` alone has no effect.
- R5: A decode instruction of class 4 to 7 never causes a stall.
- R6: `stall`, `hold_dec` and `bubble` are combinational. All three are high in the same cycle the conflicting pair sits in the execute and decode latches.
- R7: On the clock edge that ends a stall cycle, the decode latch keeps its class and register fields and stays valid. The input instruction presented in that cycle is not captured.
- R8: After a stall cycle, the execute latch is invalid (a bubble).
- R9: After a stall cycle, the memory latch holds the load that was in execute, with its `rt`.
- R10: With no stall, each clock moves the input to decode, decode to execute and execute to memory, valid flags included.
- R11: While `rst_n` is low, all latch valid flags and `stall` are low.
- R12: A given load/consumer pair stalls for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming instruction valid |
| in_class | input | 3 | Incoming instruction class code |
| in_rs | input | REG_W | Incoming first source register |
| in_rt | input | REG_W | Incoming second source / load destination register |
| stall | output | 1 | Load-use conflict present this cycle |
| hold_dec | output | 1 | Decode latch must keep its contents |
| bubble | output | 1 | Execute latch receives a bubble at the next edge |
| dec_valid | output | 1 | Decode latch valid |
| dec_class | output | 3 | Decode latch class |
| dec_rs | output | REG_W | Decode latch `rs` |
| dec_rt | output | REG_W | Decode latch `rt` |
| exe_valid | output | 1 | Execute latch valid |
| exe_class | output | 3 | Execute latch class |
| exe_rs | output | REG_W | Execute latch `rs` |
| exe_rt | output | REG_W | Execute latch `rt` |
| mem_valid | output | 1 | Memory latch valid |
| mem_class | output | 3 | Memory latch class |
| mem_rt | output | REG_W | Memory latch `rt` |

## Verification
The bench goes after consumers whose only match sits in the field their format does not read: a store or immediate op matching on `rt`, and a three-register op matching only on `rt`. A detector that compared the wrong field would stall needlessly in the first case and miss the conflict in the second. It also presents a non-load producer with a matching `rt`, an invalid decode slot with matching fields, and the "other" class codes 4 to 7; a detector that ignored the load class or the valid flags would stall on these. During every stall a fresh valid instruction is offered at the input. A latch that did not freeze would swallow it, a missing bubble would issue the consumer twice, and a stalled load that failed to advance would stall forever.

// File: rtl/lu_hz_pkg.sv
package lu_hz_pkg;

    typedef enum logic [2:0] {
        CLS_RRR   = 3'd0,
        CLS_LOAD  = 3'd1,
        CLS_STORE = 3'd2,
        CLS_IMM   = 3'd3,
        CLS_OTHER = 3'd4
    } op_class_e;

    typedef enum logic [1:0] {
        DS_EMPTY = 2'd0,
        DS_FRESH = 2'd1,
        DS_HELD  = 2'd2
    } dec_state_e;

    localparam int unsigned CLS_W   = 3;
    localparam int unsigned NUM_SRC = 2;

endpackage

// File: rtl/lu_hz_detect.sv
module lu_hz_detect
    import lu_hz_pkg::*;
#(
    parameter int unsigned REG_W = 5
) (
    input  logic             ex_valid,
    input  logic [CLS_W-1:0] ex_class,
    input  logic [REG_W-1:0] ex_rt,
    input  logic             id_valid,
    input  logic [CLS_W-1:0] id_class,
    input  logic [REG_W-1:0] id_rs,
    input  logic [REG_W-1:0] id_rt,
    output logic             stall,
    output logic             hold_id,
    output logic             bubble_ex
);

    logic [NUM_SRC-1:0] src_used;
    logic [NUM_SRC-1:0] src_hit;
    logic [REG_W-1:0]   src_reg [NUM_SRC];
    logic               producer_load;

    // Source fields read by the consumer depend on its format
    always_comb begin
        case (op_class_e'(id_class))
            CLS_RRR:                     src_used = 2'b11;
            CLS_LOAD, CLS_STORE, CLS_IMM: src_used = 2'b01;
            default:                     src_used = 2'b00;
        endcase
    end

    assign src_reg[0] = id_rs;
    assign src_reg[1] = id_rt;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src_cmp
        assign src_hit[g] = src_used[g] && (src_reg[g] == ex_rt);
    end

    assign producer_load = ex_valid && (ex_class == CLS_LOAD);
    assign stall         = producer_load && id_valid && (|src_hit);
    assign hold_id       = stall;
    assign bubble_ex     = stall;

endmodule

// File: rtl/lu_dec_fsm.sv
module lu_dec_fsm
    import lu_hz_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic stall,
    output logic dec_valid,
    output logic dec_capture,
    output logic ex_capture
);

    dec_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DS_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DS_EMPTY: state_d = in_valid ? DS_FRESH : DS_EMPTY;
            DS_FRESH,
            DS_HELD: begin
                if (stall)         state_d = DS_HELD;
                else if (in_valid) state_d = DS_FRESH;
                else               state_d = DS_EMPTY;
            end
            default: state_d = DS_EMPTY;
        endcase
    end

    always_comb begin
        dec_valid   = 1'b0;
        dec_capture = 1'b1;
        ex_capture  = 1'b1;
        unique case (state_q)
            DS_EMPTY: dec_valid = 1'b0;
            DS_FRESH,
            DS_HELD: begin
                dec_valid   = 1'b1;
                dec_capture = !stall;
                ex_capture  = !stall;
            end
            default: dec_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/lu_stall_pipe.sv
module lu_stall_pipe
    import lu_hz_pkg::*;
#(
    parameter int unsigned REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [2:0]       in_class,
    input  logic [REG_W-1:0] in_rs,
    input  logic [REG_W-1:0] in_rt,
    output logic             stall,
    output logic             hold_dec,
    output logic             bubble,
    output logic             dec_valid,
    output logic [2:0]       dec_class,
    output logic [REG_W-1:0] dec_rs,
    output logic [REG_W-1:0] dec_rt,
    output logic             exe_valid,
    output logic [2:0]       exe_class,
    output logic [REG_W-1:0] exe_rs,
    output logic [REG_W-1:0] exe_rt,
    output logic             mem_valid,
    output logic [2:0]       mem_class,
    output logic [REG_W-1:0] mem_rt
);

    logic dec_capture;
    logic ex_capture;

    lu_hz_detect #(.REG_W(REG_W)) u_detect (
        .ex_valid  (exe_valid),
        .ex_class  (exe_class),
        .ex_rt     (exe_rt),
        .id_valid  (dec_valid),
        .id_class  (dec_class),
        .id_rs     (dec_rs),
        .id_rt     (dec_rt),
        .stall     (stall),
        .hold_id   (hold_dec),
        .bubble_ex (bubble)
    );

    lu_dec_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .stall       (stall),
        .dec_valid   (dec_valid),
        .dec_capture (dec_capture),
        .ex_capture  (ex_capture)
    );

    // Decode latch fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_class <= '0;
            dec_rs    <= '0;
            dec_rt    <= '0;
        end else if (dec_capture) begin
            dec_class <= in_class;
            dec_rs    <= in_rs;
            dec_rt    <= in_rt;
        end
    end

    // Execute latch: takes decode, or a bubble during a stall
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exe_valid <= 1'b0;
            exe_class <= '0;
            exe_rs    <= '0;
            exe_rt    <= '0;
        end else if (ex_capture) begin
            exe_valid <= dec_valid;
            exe_class <= dec_class;
            exe_rs    <= dec_rs;
            exe_rt    <= dec_rt;
        end else begin
            exe_valid <= 1'b0;
        end
    end

    // Memory latch: execute always moves on
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_valid <= 1'b0;
            mem_class <= '0;
            mem_rt    <= '0;
        end else begin
            mem_valid <= exe_valid;
            mem_class <= exe_class;
            mem_rt    <= exe_rt;
        end
    end

endmodule

// File: rtl/lu_stall_chk.sv
module lu_stall_chk
    import lu_hz_pkg::*;
#(
    parameter int unsigned REG_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stall,
    input logic             dec_valid,
    input logic [2:0]       dec_class,
    input logic [REG_W-1:0] dec_rs,
    input logic [REG_W-1:0] dec_rt,
    input logic             exe_valid,
    input logic [2:0]       exe_class,
    input logic [REG_W-1:0] exe_rt,
    input logic             mem_valid,
    input logic [REG_W-1:0] mem_rt
);

    // R1
    stall_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (exe_valid && exe_class == CLS_LOAD));

    // R2
    stall_needs_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> dec_valid);

    // R3
    rrr_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exe_valid && exe_class == CLS_LOAD && dec_valid && dec_class == CLS_RRR
         && (exe_rt == dec_rs || exe_rt == dec_rt)) |-> stall);

    // R5
    other_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_class >= 3'd4) |-> !stall);

    // R7
    hold_keeps_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (dec_valid && $stable(dec_class) && $stable(dec_rs) && $stable(dec_rt)));

    // R8
    bubble_after_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !exe_valid);

    // R9
    load_moves_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (mem_valid && mem_rt == $past(exe_rt)));

    // R12
    single_cycle_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

endmodule

bind lu_stall_pipe lu_stall_chk #(.REG_W(REG_W)) u_stall_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stall     (stall),
    .dec_valid (dec_valid),
    .dec_class (dec_class),
    .dec_rs    (dec_rs),
    .dec_rt    (dec_rt),
    .exe_valid (exe_valid),
    .exe_class (exe_class),
    .exe_rt    (exe_rt),
    .mem_valid (mem_valid),
    .mem_rt    (mem_rt)
);

// File: tb/tb_lu_stall_pipe.sv
module tb_lu_stall_pipe;

    localparam int RW = 5;

    typedef struct packed {
        logic          v;
        logic [2:0]    c;
        logic [RW-1:0] rs;
        logic [RW-1:0] rt;
    } ins_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [2:0]    in_class = 3'd4;
    logic [RW-1:0] in_rs = '0;
    logic [RW-1:0] in_rt = '0;
    logic          stall, hold_dec, bubble;
    logic          dec_valid, exe_valid, mem_valid;
    logic [2:0]    dec_class, exe_class, mem_class;
    logic [RW-1:0] dec_rs, dec_rt, exe_rs, exe_rt, mem_rt;

    lu_stall_pipe #(.REG_W(RW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
        .in_rs(in_rs), .in_rt(in_rt), .stall(stall), .hold_dec(hold_dec),
        .bubble(bubble), .dec_valid(dec_valid), .dec_class(dec_class),
        .dec_rs(dec_rs), .dec_rt(dec_rt), .exe_valid(exe_valid),
        .exe_class(exe_class), .exe_rs(exe_rs), .exe_rt(exe_rt),
        .mem_valid(mem_valid), .mem_class(mem_class), .mem_rt(mem_rt)
    );

    always #4 clk = ~clk;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 0;
    bit    last_s = 0;
    string focus = "R11";
    ins_t  q[$];

    // Reference latches
    bit m_dv, m_ev, m_mv;
    int m_dc, m_drs, m_drt, m_ec, m_ers, m_ert, m_mc, m_mrt;

    function automatic bit ref_stall();
        if (!(m_ev && m_ec == 1)) return 0;          // R1
        if (!m_dv) return 0;                          // R2
        if (m_dc == 0) return (m_ert == m_drs) || (m_ert == m_drt);  // R3
        if (m_dc >= 1 && m_dc <= 3) return m_ert == m_drs;           // R4
        return 0;                                     // R5
    endfunction

    task automatic compare();
        bit    e = ref_stall();
        string msg = "";
        n_cmp++;
        // R6: all three strobes follow the conflict in the same cycle
        if (stall !== e)    msg = {msg, $sformatf(" stall=%0b exp=%0b", stall, e)};
        if (hold_dec !== e) msg = {msg, $sformatf(" hold_dec=%0b exp=%0b", hold_dec, e)};
        if (bubble !== e)   msg = {msg, $sformatf(" bubble=%0b exp=%0b", bubble, e)};
        if (dec_valid !== m_dv) msg = {msg, $sformatf(" dec_valid=%0b exp=%0b", dec_valid, m_dv)};
        if (exe_valid !== m_ev) msg = {msg, $sformatf(" exe_valid=%0b exp=%0b", exe_valid, m_ev)};
        if (mem_valid !== m_mv) msg = {msg, $sformatf(" mem_valid=%0b exp=%0b", mem_valid, m_mv)};
        if (m_dv && (int'(dec_class) != m_dc || int'(dec_rs) != m_drs || int'(dec_rt) != m_drt))
            msg = {msg, $sformatf(" dec=%0d/%0d/%0d exp=%0d/%0d/%0d",
                   dec_class, dec_rs, dec_rt, m_dc, m_drs, m_drt)};
        if (m_ev && (int'(exe_class) != m_ec || int'(exe_rs) != m_ers || int'(exe_rt) != m_ert))
            msg = {msg, $sformatf(" exe=%0d/%0d/%0d exp=%0d/%0d/%0d",
                   exe_class, exe_rs, exe_rt, m_ec, m_ers, m_ert)};
        if (m_mv && (int'(mem_class) != m_mc || int'(mem_rt) != m_mrt))
            msg = {msg, $sformatf(" mem=%0d/%0d exp=%0d/%0d", mem_class, mem_rt, m_mc, m_mrt)};
        if (msg != "") begin
            n_bad++;
            $display("FAIL %s t=%0t:%s", focus, $time, msg);
        end
    endtask

    // Drive away from the edge, check, then advance the reference at the edge
    task automatic step(input bit v, input int c, input int rs, input int rt);
        bit s;
        in_valid = v;
        in_class = 3'(c);
        in_rs    = RW'(rs);
        in_rt    = RW'(rt);
        #1;
        compare();
        s = ref_stall();
        last_s = s;
        @(posedge clk);
        m_mv = m_ev; m_mc = m_ec; m_mrt = m_ert;           // R9 / R10
        if (s) begin
            m_ev = 0;                                      // R8
        end else begin
            m_ev = m_dv; m_ec = m_dc; m_ers = m_drs; m_ert = m_drt;
            m_dv = v; m_dc = c; m_drs = rs; m_drt = rt;    // R10
        end                                                // else R7: decode kept
        @(negedge clk);
    endtask

    task automatic push(input bit v, input int c, input int rs, input int rt);
        ins_t x;
        x.v = v; x.c = 3'(c); x.rs = RW'(rs); x.rt = RW'(rt);
        q.push_back(x);
    endtask

    // Front end that re-offers an instruction while the reference stalls
    task automatic run_q();
        while (q.size() > 0) begin
            step(q[0].v, int'(q[0].c), int'(q[0].rs), int'(q[0].rt));
            if (!last_s) void'(q.pop_front());
        end
        repeat (3) step(0, 4, 0, 0);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        m_dv = 0; m_ev = 0; m_mv = 0;
        m_dc = 0; m_drs = 0; m_drt = 0; m_ec = 0; m_ers = 0; m_ert = 0; m_mc = 0; m_mrt = 0;
        repeat (3) @(negedge clk);
        focus = "R11";
        in_valid = 1'b1; in_class = 3'd1;
        #1 compare();                         // R11: all valids low under reset
        @(negedge clk);
        compare();
        rst_n = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);

        focus = "R10";                        // plain flow, no conflict
        push(1, 4, 1, 2); push(1, 0, 3, 4); push(1, 2, 5, 6); push(1, 3, 7, 8);
        push(1, 1, 9, 10); push(1, 0, 11, 12);
        run_q();

        focus = "R3";                         // three-register consumer, rs match
        push(1, 1, 0, 5); push(1, 0, 5, 9); push(1, 4, 20, 21);
        run_q();
        focus = "R3";                         // three-register consumer, rt-only match
        push(1, 1, 0, 5); push(1, 0, 9, 5); push(1, 4, 20, 21);
        run_q();
        push(1, 1, 0, 5); push(1, 0, 2, 3);   // R3 no match
        run_q();

        focus = "R4";                         // base-only consumers
        push(1, 1, 0, 7); push(1, 2, 7, 1);   // store on rs: stall
        push(1, 1, 0, 7); push(1, 2, 1, 7);   // store on rt only: ignored
        push(1, 1, 0, 7); push(1, 3, 7, 2);   // immediate on rs: stall
        push(1, 1, 0, 7); push(1, 3, 3, 7);   // immediate on rt only: ignored
        push(1, 1, 0, 7); push(1, 1, 7, 4);   // load on rs: stall
        push(1, 1, 0, 7); push(1, 1, 4, 7);   // load on rt only: ignored
        run_q();

        focus = "R5";                         // other classes
        push(1, 1, 0, 7); push(1, 4, 7, 7);
        push(1, 1, 0, 7); push(1, 5, 7, 7);
        push(1, 1, 0, 7); push(1, 7, 7, 7);
        run_q();

        focus = "R1";                         // non-load producers
        push(1, 2, 0, 7); push(1, 0, 7, 7);
        push(1, 0, 0, 7); push(1, 0, 7, 7);
        push(1, 3, 0, 7); push(1, 3, 7, 7);
        run_q();

        focus = "R2";                         // invalid decode slot
        step(1, 1, 0, 7); step(0, 0, 7, 7); step(0, 0, 7, 7);
        repeat (3) step(0, 4, 0, 0);

        focus = "R7";                         // a valid fetch offered during the stall is not taken
        step(1, 1, 0, 6); step(1, 0, 6, 1);
        step(1, 4, 30, 31);                   // stall cycle: this one is dropped
        step(1, 4, 29, 28);
        repeat (3) step(0, 4, 0, 0);

        focus = "R12";                        // chained load-use pairs, one stall each
        push(1, 1, 0, 3); push(1, 1, 3, 4); push(1, 3, 4, 5); push(1, 0, 5, 5);
        run_q();

        focus = "R9";                         // back-to-back loads feeding memory
        push(1, 1, 0, 8); push(1, 1, 8, 9); push(1, 2, 9, 9);
        run_q();

        done = 1;
        summary();
        $finish;
    end

endmodule